// File: doc/BRIEF.md
# Processor Status Flag Register

This block is the eight-bit status register of a small processor core. It stores the global interrupt enable, a one-bit copy slot used by bit-transfer instructions, and six arithmetic condition flags. The arithmetic unit computes its flags elsewhere. This block only latches them, under a per-flag enable mask. It also derives the sign flag as negative XOR overflow on every arithmetic update.

Several other sources change the register. A bit-store command copies one chosen bit of an operand into the copy slot. A combinational bit-load path returns the operand with that bit replaced by the slot. Taking an interrupt clears the global enable, and returning from an interrupt sets it. A full-byte write from the register bus overwrites everything, and a conflicting cycle is settled by a fixed priority. A registered interrupt-allow output follows the global enable for the interrupt controller.

Top module: `flag_status_reg`

## Requirements
- R1: A cycle with `rst` high clears every bit of `sreg_q` and clears `int_allow`, as seen after that clock edge.
- R2: Bit positions of `sreg_q` and `bus_wdata` from bit 7 to bit 0 are: interrupt enable, copy slot, half carry, sign, overflow, negative, zero, carry. When `bus_we` is high, all eight bits are loaded exactly as written, including the sign bit.
- R3: When `alu_we` is high, each of bits 5, 3, 2, 1 and 0 whose `alu_mask` bit is one takes the value of the same bit of `alu_flags`, and each of them whose mask bit is zero keeps its value. Bits 7, 6 and 4 of `alu_mask` and `alu_flags` have no effect.
- R4: After a cycle with `alu_we` high and no bus write, bit 4 equals bit 2 XOR bit 3 of the updated value. This holds even when the mask enables none of those flags.
- R5: When `bst_en` is high, bit 6 takes `operand[bit_sel]`.
- R6: `bld_result` equals `operand` with the bit at position `bit_sel` replaced by the current bit 6. It is combinational.
- R7: `irq_take` clears bit 7 at the next edge. It overrides `irq_ret` and a bus write in the same cycle.
- R8: `irq_ret` without `irq_take` sets bit 7 at the next edge. It overrides a bus write in the same cycle.
- R9: `int_allow` is a register that always equals bit 7 of `sreg_q`.
- R10: For bits 6 down to 0, a bus write overrides an arithmetic update and a bit-store in the same cycle.
- R11: In a cycle with no command active, `sreg_q` keeps its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| alu_we | input | 1 | Arithmetic flag update strobe |
| alu_mask | input | 8 | Per-flag enable for the update |
| alu_flags | input | 8 | Flag values from the arithmetic unit |
| bst_en | input | 1 | Bit-store into the copy slot |
| bit_sel | input | 3 | Bit position for bit-store and bit-load |
| operand | input | DATA_W | Register operand for bit-store and bit-load |
| irq_take | input | 1 | Interrupt entry event |
| irq_ret | input | 1 | Return-from-interrupt event |
| bus_we | input | 1 | Full-byte register bus write |
| bus_wdata | input | 8 | Bus write data |
| sreg_q | output | 8 | Current status register value |
| bld_result | output | DATA_W | Operand with the selected bit replaced by the copy slot |
| int_allow | output | 1 | Registered global interrupt allow |

## Verification
A flag stored into the wrong bit position, or merged under the wrong mask bit, shows on `sreg_q` at the very next clock edge. The bench compares every bit there against hand-derived values. A stale or wrongly derived sign bit also shows one edge after the arithmetic update. The bench includes an update whose mask enables nothing, because a sign bit left unrecomputed would otherwise stay hidden. A wrong priority between interrupt events and the bus write shows as the wrong bit 7 and `int_allow` after that same edge. A copy slot captured from the wrong bit appears on `bld_result` in the same cycle, with no edge in between.

// File: rtl/sflag_pkg.sv
package sflag_pkg;

    localparam int unsigned SR_W = 8;

    localparam int unsigned POS_C = 0;
    localparam int unsigned POS_Z = 1;
    localparam int unsigned POS_N = 2;
    localparam int unsigned POS_V = 3;
    localparam int unsigned POS_S = 4;
    localparam int unsigned POS_H = 5;
    localparam int unsigned POS_T = 6;
    localparam int unsigned POS_I = 7;

    // Bits the arithmetic unit may write through its mask
    localparam logic [SR_W-1:0] ALU_OWNED = 8'b0010_1111;

    typedef struct packed {
        logic ie;
        logic cpy;
        logic hc;
        logic sg;
        logic ov;
        logic ng;
        logic zr;
        logic cy;
    } sflags_t;

    function automatic logic sign_of(input logic neg, input logic ovf);
        return neg ^ ovf;
    endfunction

endpackage

// File: rtl/sflag_alu_merge.sv
module sflag_alu_merge
    import sflag_pkg::*;
(
    input  sflags_t          cur,
    input  logic             alu_we,
    input  logic [SR_W-1:0]  alu_mask,
    input  logic [SR_W-1:0]  alu_flags,
    output sflags_t          nxt
);
    logic [SR_W-1:0] cur_v;
    logic [SR_W-1:0] merged;
    logic            unused_ctl;

    assign cur_v = cur;

    for (genvar k = 0; k < SR_W; k++) begin : g_bit
        if (ALU_OWNED[k]) begin : g_owned
            assign merged[k] = (alu_we && alu_mask[k]) ? alu_flags[k] : cur_v[k];
        end else begin : g_kept
            assign merged[k] = cur_v[k];
        end
    end

    assign unused_ctl = ^{alu_mask & ~ALU_OWNED, alu_flags & ~ALU_OWNED};

    always_comb begin
        nxt = sflags_t'(merged);
        if (alu_we) begin
            nxt.sg = sign_of(merged[POS_N], merged[POS_V]);
        end
    end

endmodule

// File: rtl/sflag_bitcopy.sv
module sflag_bitcopy #(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned SEL_W = $clog2(DATA_W)
) (
    input  logic              slot,
    input  logic [DATA_W-1:0] operand,
    input  logic [SEL_W-1:0]  bit_sel,
    output logic              picked,
    output logic [DATA_W-1:0] inserted
);
    assign picked = operand[bit_sel];

    for (genvar k = 0; k < DATA_W; k++) begin : g_ins
        assign inserted[k] = (bit_sel == SEL_W'(k)) ? slot : operand[k];
    end

endmodule

// File: rtl/sflag_irq_ctrl.sv
module sflag_irq_ctrl (
    input  logic cur_ie,
    input  logic irq_take,
    input  logic irq_ret,
    input  logic bus_we,
    input  logic bus_ie,
    output logic nxt_ie
);
    // Priority: entry, then return, then bus write, then hold
    always_comb begin
        if (irq_take)      nxt_ie = 1'b0;
        else if (irq_ret)  nxt_ie = 1'b1;
        else if (bus_we)   nxt_ie = bus_ie;
        else               nxt_ie = cur_ie;
    end

endmodule

// File: rtl/flag_status_reg.sv
module flag_status_reg
    import sflag_pkg::*;
#(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned SEL_W = $clog2(DATA_W)
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              alu_we,
    input  logic [7:0]        alu_mask,
    input  logic [7:0]        alu_flags,
    input  logic              bst_en,
    input  logic [SEL_W-1:0]  bit_sel,
    input  logic [DATA_W-1:0] operand,
    input  logic              irq_take,
    input  logic              irq_ret,
    input  logic              bus_we,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        sreg_q,
    output logic [DATA_W-1:0] bld_result,
    output logic              int_allow
);
    sflags_t cur_q;
    sflags_t alu_nxt;
    sflags_t low_nxt;
    sflags_t bus_v;
    sflags_t d_nxt;
    logic    picked;
    logic    ie_nxt;

    assign bus_v = sflags_t'(bus_wdata);

    sflag_alu_merge u_alu (
        .cur       (cur_q),
        .alu_we    (alu_we),
        .alu_mask  (alu_mask),
        .alu_flags (alu_flags),
        .nxt       (alu_nxt)
    );

    sflag_bitcopy #(.DATA_W(DATA_W)) u_copy (
        .slot     (cur_q.cpy),
        .operand  (operand),
        .bit_sel  (bit_sel),
        .picked   (picked),
        .inserted (bld_result)
    );

    sflag_irq_ctrl u_irq (
        .cur_ie   (cur_q.ie),
        .irq_take (irq_take),
        .irq_ret  (irq_ret),
        .bus_we   (bus_we),
        .bus_ie   (bus_v.ie),
        .nxt_ie   (ie_nxt)
    );

    always_comb begin
        low_nxt = alu_nxt;
        if (bst_en) low_nxt.cpy = picked;
        if (bus_we) low_nxt = bus_v;
        d_nxt    = low_nxt;
        d_nxt.ie = ie_nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cur_q     <= '0;
            int_allow <= 1'b0;
        end else begin
            cur_q     <= d_nxt;
            int_allow <= ie_nxt;
        end
    end

    assign sreg_q = cur_q;

endmodule

// File: rtl/sflag_chk.sv
module sflag_chk #(
    parameter int unsigned DATA_W = 8,
    localparam int unsigned SEL_W = $clog2(DATA_W)
) (
    input logic              clk,
    input logic              rst,
    input logic              alu_we,
    input logic [7:0]        alu_mask,
    input logic [7:0]        alu_flags,
    input logic              bst_en,
    input logic [SEL_W-1:0]  bit_sel,
    input logic [DATA_W-1:0] operand,
    input logic              irq_take,
    input logic              irq_ret,
    input logic              bus_we,
    input logic [7:0]        bus_wdata,
    input logic [7:0]        sreg_q,
    input logic [DATA_W-1:0] bld_result,
    input logic              int_allow
);
    // R4
    a_r4_sign_derived: assert property (@(posedge clk) disable iff (rst)
        alu_we && !bus_we |=> sreg_q[4] == (sreg_q[3] ^ sreg_q[2]));

    // R3
    a_r3_carry_masked_hold: assert property (@(posedge clk) disable iff (rst)
        alu_we && !alu_mask[0] && !bus_we |=> $stable(sreg_q[0]));

    // R5
    a_r5_store_copy: assert property (@(posedge clk) disable iff (rst)
        bst_en && !bus_we |=> sreg_q[6] == $past(operand[bit_sel]));

    // R7
    a_r7_entry_clears: assert property (@(posedge clk) disable iff (rst)
        irq_take |=> !sreg_q[7]);

    // R8
    a_r8_return_sets: assert property (@(posedge clk) disable iff (rst)
        irq_ret && !irq_take |=> sreg_q[7]);

    // R9
    a_r9_allow_tracks: assert property (@(posedge clk) disable iff (rst)
        int_allow == sreg_q[7]);

    // R11
    a_r11_idle_hold: assert property (@(posedge clk) disable iff (rst)
        !alu_we && !bst_en && !irq_take && !irq_ret && !bus_we |=> $stable(sreg_q));

    // R10
    a_r10_bus_wins: assert property (@(posedge clk) disable iff (rst)
        bus_we |=> sreg_q[6:0] == $past(bus_wdata[6:0]));

endmodule

bind flag_status_reg sflag_chk #(.DATA_W(DATA_W)) u_chk (.*);

// File: tb/tb_flag_status_reg.sv
module tb_flag_status_reg;

    logic       clk = 1'b0;
    logic       rst;
    logic       alu_we;
    logic [7:0] alu_mask;
    logic [7:0] alu_flags;
    logic       bst_en;
    logic [2:0] bit_sel;
    logic [7:0] operand;
    logic       irq_take;
    logic       irq_ret;
    logic       bus_we;
    logic [7:0] bus_wdata;
    logic [7:0] sreg_q;
    logic [7:0] bld_result;
    logic       int_allow;

    int n_run  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    flag_status_reg dut (
        .clk(clk), .rst(rst), .alu_we(alu_we), .alu_mask(alu_mask),
        .alu_flags(alu_flags), .bst_en(bst_en), .bit_sel(bit_sel),
        .operand(operand), .irq_take(irq_take), .irq_ret(irq_ret),
        .bus_we(bus_we), .bus_wdata(bus_wdata), .sreg_q(sreg_q),
        .bld_result(bld_result), .int_allow(int_allow)
    );

    typedef struct packed {
        logic       bw;
        logic [7:0] bd;
        logic       aw;
        logic [7:0] am;
        logic [7:0] af;
        logic       sw;
        logic [2:0] sel;
        logic [7:0] op;
        logic       tk;
        logic       rt;
        logic [7:0] ex;
    } vec_t;

    localparam int NV = 14;
    // fields: bw bd aw am af sw sel op tk rt expected
    localparam logic [47:0] VEC [NV] = '{
        {1'b1, 8'h5A, 1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 8'h5A}, // R2 raw byte incl. sign
        {1'b0, 8'h00, 1'b1, 8'hFF, 8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 8'h40}, // R3 all arith flags
        {1'b0, 8'h00, 1'b1, 8'h05, 8'hFF, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 8'h55}, // R3 R4 N,C only
        {1'b0, 8'h00, 1'b1, 8'h08, 8'h08, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 8'h4D}, // R4 V set -> S clear
        {1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 1'b1, 3'd6, 8'h00, 1'b0, 1'b0, 8'h0D}, // R5 store zero
        {1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 8'h8D}, // R8 return
        {1'b1, 8'hFF, 1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 8'h00, 1'b1, 1'b0, 8'h7F}, // R7 entry beats bus
        {1'b0, 8'h00, 1'b1, 8'h00, 8'hFF, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 8'h6F}, // R4 empty mask
        {1'b1, 8'h00, 1'b1, 8'hFF, 8'hFF, 1'b1, 3'd0, 8'hFF, 1'b0, 1'b0, 8'h00}, // R10 bus beats alu/store
        {1'b1, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 1'b1, 8'h80}, // R8 return beats bus
        {1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 8'h00, 1'b1, 1'b1, 8'h00}, // R7 entry beats return
        {1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 1'b1, 3'd7, 8'h80, 1'b0, 1'b0, 8'h40}, // R5 store one
        {1'b0, 8'h00, 1'b1, 8'hD0, 8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 8'h40}, // R3 ignored mask bits
        {1'b0, 8'h00, 1'b0, 8'h00, 8'h00, 1'b0, 3'd0, 8'h00, 1'b0, 1'b0, 8'h40}  // R11 idle hold
    };

    task automatic idle_inputs();
        alu_we = 0; alu_mask = 0; alu_flags = 0; bst_en = 0; bit_sel = 0;
        operand = 0; irq_take = 0; irq_ret = 0; bus_we = 0; bus_wdata = 0;
    endtask

    task automatic check8(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    initial begin
        #1_000_000;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        idle_inputs();
        rst = 1;
        @(posedge clk);
        @(negedge clk);
        check8("R1 reset sreg", sreg_q, 8'h00);
        check8("R1 reset allow", {7'd0, int_allow}, 8'h00);
        rst = 0;

        for (int i = 0; i < NV; i++) begin
            vec_t v;
            v = VEC[i];
            bus_we = v.bw; bus_wdata = v.bd; alu_we = v.aw; alu_mask = v.am;
            alu_flags = v.af; bst_en = v.sw; bit_sel = v.sel; operand = v.op;
            irq_take = v.tk; irq_ret = v.rt;
            @(posedge clk);
            @(negedge clk);
            idle_inputs();
            check8($sformatf("R2-vector %0d sreg", i), sreg_q, v.ex);
            check8($sformatf("R9 vector %0d allow", i), {7'd0, int_allow}, {7'd0, v.ex[7]});
        end

        // R6: copy slot currently 1 (state 40)
        operand = 8'h00; bit_sel = 3'd3; #1;
        check8("R6 insert one", bld_result, 8'h08);
        operand = 8'hA5; bit_sel = 3'd6; #1;
        check8("R6 insert one at 6", bld_result, 8'hE5);
        // clear slot via bit-store, then insert zero
        bst_en = 1; operand = 8'hBF; bit_sel = 3'd6;
        @(posedge clk); @(negedge clk);
        idle_inputs();
        check8("R5 store from bit 6", sreg_q, 8'h00);
        operand = 8'hFF; bit_sel = 3'd5; #1;
        check8("R6 insert zero", bld_result, 8'hDF);

        // R1: reset in the middle of a run
        bus_we = 1; bus_wdata = 8'hFF;
        @(posedge clk); @(negedge clk);
        idle_inputs();
        check8("R2 full write", sreg_q, 8'hFF);
        check8("R9 allow after write", {7'd0, int_allow}, 8'h01);
        rst = 1; bus_we = 1; bus_wdata = 8'h3C;
        @(posedge clk); @(negedge clk);
        rst = 0; idle_inputs();
        check8("R1 reset beats write", sreg_q, 8'h00);
        check8("R1 allow cleared", {7'd0, int_allow}, 8'h00);

        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule